// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects eight peripheral request lines and presents them to a processor that has one interrupt input. A new request on a line is captured in a per-line latch. The latch is gated by a software-written enable register before the controller looks for the most urgent line, and line 0 is the most urgent. When a gated request outranks whatever is being serviced, the controller raises its interrupt output. The processor then pulses an acknowledge. The controller answers with a vector code equal to a programmable base plus the winning line index, and it also gives the service-table address, which is four times that code. The acknowledged line moves from pending to in-service.

The in-service state is held as one bit per line, so service routines can nest. A more urgent request preempts the running level. A less urgent request, or a new request on the level already running, waits in its latch. An end-of-service pulse retires the most urgent in-service level. The interrupt output is then recomputed against the level that was interrupted. A waiting request causes a new interrupt only if it outranks that level. Otherwise control simply returns to the interrupted level.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A latched request counts only while its bit in the enable register is 1 (bit i enables line i). While its bit is 0 it never raises `cpu_int`, but it stays latched and is served once the bit is set.
- R2: A request is latched on a 0-to-1 transition of its `irq_req` bit. A line held high is latched only once and is not latched again after its acknowledge.
- R3: With nothing in service, `cpu_int` is high in the cycle after an enabled request is latched. When several enabled requests are latched, the lowest line index wins.
- R4: When `inta` is sampled high while `cpu_int` is high, `vec_valid` is high for exactly the next cycle. `vec_out` then shows the vector. The winner's latch is cleared and its in-service bit is set.
- R5: An enabled request whose index is lower than the lowest in-service index raises `cpu_int` (preemption).
- R6: A request whose index is equal to or higher than the lowest in-service index stays pending and does not raise `cpu_int`.
- R7: A pulse on `eoi` clears the lowest-index in-service bit. After that, `cpu_int` is high only if a pending enabled request outranks the remaining lowest in-service index, or if nothing remains in service.
- R8: `inta` sampled while `cpu_int` is low is ignored. No `vec_valid` follows, and no latch or in-service bit changes.
- R9: `svc_addr` equals `vec_out` multiplied by four (`vec_out` shifted left by two bits).
- R10: Reset clears the latches, the in-service bits, the enable register (all lines disabled) and the vector base. `cpu_int` and `vec_valid` are low after reset.
- R11: The vector is the 8-bit base register plus the winning line index, modulo 256. A write to the base register is used by any acknowledge taken from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Peripheral request lines, latched on rising transitions |
| mask_we | input | 1 | Write strobe for the enable register |
| mask_wdata | input | 8 | New enable register value, 1 enables a line |
| base_we | input | 1 | Write strobe for the vector base register |
| base_wdata | input | 8 | New vector base value |
| inta | input | 1 | Processor acknowledge |
| eoi | input | 1 | End-of-service command |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector code of the last acknowledge |
| vec_valid | output | 1 | One-cycle strobe qualifying `vec_out` |
| svc_addr | output | 10 | Service-table address for `vec_out` |

## Verification
The main function is tried first with a single request on one line. This separates the latch-and-acknowledge path from the priority logic. Two lines are then raised in the same cycle, which checks that the lower index wins. A nesting sequence follows. A low-urgency line is served first. A more urgent line preempts it, and a middle line then arrives and must wait. A repeat of the running line must also wait. Two successive end-of-service pulses then show whether the waiting middle line fires before control returns to the preempted level, and whether the equal-level repeat is held back until the stack is empty. Masked requests, spurious acknowledges and a base rewrite show the gating, the ignore path and the vector arithmetic. A behavioural model is compared with the outputs on every cycle.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // shift between a vector code and its service-table byte address
  localparam int unsigned TBL_SHIFT = 2;

  // encoded in-service command for the stack tracker
  typedef struct packed {
    logic push;   // a grant is taken this cycle
    logic pop;    // end-of-service this cycle
  } isr_cmd_t;
endpackage

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_in,
  input  logic [N_LINES-1:0] clr_oh,
  output logic [N_LINES-1:0] lat_q
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] lat_d;
  logic [N_LINES-1:0] rise;

  always_comb begin
    rise  = req_in & ~prev_q;
    // a fresh edge wins over a clear in the same cycle
    lat_d = (lat_q & ~clr_oh) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= req_in;
      lat_q  <= lat_d;
    end
  end
endmodule

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] vec_in,
  output logic               any,
  output logic [IW-1:0]      idx,
  output logic [N_LINES-1:0] first_oh
);
  always_comb begin
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (vec_in[i]) idx = IW'(i);
    end
    any      = |vec_in;
    first_oh = vec_in & (~vec_in + N_LINES'(1));
  end
endmodule

// File: rtl/nic_isr_track.sv
module nic_isr_track
  import nic_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  isr_cmd_t           cmd,
  input  logic [N_LINES-1:0] push_oh,
  input  logic [N_LINES-1:0] top_oh,
  output logic [N_LINES-1:0] isr_q
);
  logic [N_LINES-1:0] isr_d;
  logic               isr_en;

  always_comb begin
    isr_en = cmd.push | cmd.pop;
    isr_d  = isr_q;
    if (cmd.pop)  isr_d = isr_d & ~top_oh;
    if (cmd.push) isr_d = isr_d | push_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned VEC_W   = 8,
  localparam int unsigned IW     = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int unsigned ADDR_W = VEC_W + TBL_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               mask_we,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic               base_we,
  input  logic [VEC_W-1:0]   base_wdata,
  input  logic               inta,
  input  logic               eoi,
  output logic               cpu_int,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic [ADDR_W-1:0]  svc_addr
);
  logic [N_LINES-1:0] lat_q;
  logic [N_LINES-1:0] mask_q;
  logic [VEC_W-1:0]   base_q;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               vv_q;
  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] pend;
  logic               req_any, isr_any;
  logic [IW-1:0]      req_idx, isr_idx;
  logic [N_LINES-1:0] req_oh, isr_oh;
  logic               int_w, grant;
  logic [N_LINES-1:0] grant_oh;
  isr_cmd_t           cmd;

  nic_req_latch #(.N_LINES(N_LINES)) u_lat (
    .clk(clk), .rst_n(rst_n), .req_in(irq_req), .clr_oh(grant_oh), .lat_q(lat_q)
  );

  assign pend = lat_q & mask_q;

  nic_prio_pick #(.N_LINES(N_LINES)) u_pick_req (
    .vec_in(pend), .any(req_any), .idx(req_idx), .first_oh(req_oh)
  );

  nic_prio_pick #(.N_LINES(N_LINES)) u_pick_isr (
    .vec_in(isr_q), .any(isr_any), .idx(isr_idx), .first_oh(isr_oh)
  );

  always_comb begin
    int_w    = req_any && (!isr_any || (req_idx < isr_idx));
    grant    = inta && int_w;
    grant_oh = grant ? req_oh : '0;
    cmd.push = grant;
    cmd.pop  = eoi;
    vec_d    = grant ? (base_q + VEC_W'(req_idx)) : vec_q;
  end

  nic_isr_track #(.N_LINES(N_LINES)) u_isr (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .push_oh(grant_oh),
    .top_oh(isr_oh), .isr_q(isr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      vec_q  <= '0;
      vv_q   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (base_we) base_q <= base_wdata;
      if (grant)   vec_q  <= vec_d;
      vv_q <= grant;
    end
  end

  assign cpu_int   = int_w;
  assign vec_out   = vec_q;
  assign vec_valid = vv_q;
  assign svc_addr  = {vec_q, {TBL_SHIFT{1'b0}}};
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int unsigned N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inta,
  input logic               eoi,
  input logic               cpu_int,
  input logic               vec_valid,
  input logic [N_LINES-1:0] lat_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] isr_q
);
  // R1: an interrupt needs an enabled latched request
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((lat_q & mask_q) != '0));

  // R4: a vector strobe follows only a taken acknowledge
  p_vec_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta && cpu_int));

  // R4: a grant without end-of-service adds one in-service level
  p_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && cpu_int && !eoi) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  // R7: end-of-service alone removes exactly one level
  p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(inta && cpu_int) && (isr_q != '0)) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R8: an acknowledge without an interrupt gives no vector
  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !cpu_int) |=> !vec_valid);

  // R8: an acknowledge without an interrupt leaves in-service state alone
  p_spurious_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !cpu_int && !eoi) |=> $stable(isr_q));
endmodule

bind nested_irq_ctrl nic_checker #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .eoi(eoi), .cpu_int(cpu_int),
  .vec_valid(vec_valid), .lat_q(lat_q), .mask_q(mask_q), .isr_q(isr_q)
);

// File: tb/sim_nested_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nested_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_req;
  logic       mask_we;
  logic [7:0] mask_wdata;
  logic       base_we;
  logic [7:0] base_wdata;
  logic       inta;
  logic       eoi;
  logic       cpu_int;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic [9:0] svc_addr;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  nested_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .base_we(base_we), .base_wdata(base_wdata),
    .inta(inta), .eoi(eoi), .cpu_int(cpu_int), .vec_out(vec_out),
    .vec_valid(vec_valid), .svc_addr(svc_addr)
  );

  // behavioural reference state
  bit [7:0] m_prev, m_lat, m_en, m_isr, m_base, m_vec;
  bit       m_vv;

  function automatic int lowest(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit model_int();
    int w = lowest(m_lat & m_en);
    int c = lowest(m_isr);
    return (w < 8) && (w < c);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_lat = '0; m_en = '0; m_isr = '0;
      m_base = '0; m_vec = '0; m_vv = 0;
    end else begin : upd
      int w, c;
      bit g;
      bit [7:0] nl, ni;
      w  = lowest(m_lat & m_en);
      c  = lowest(m_isr);
      g  = inta && (w < 8) && (w < c);
      nl = m_lat;
      ni = m_isr;
      if (eoi && c < 8) ni[c] = 0;
      if (g) begin
        ni[w] = 1;
        nl[w] = 0;
        m_vec = m_base + 8'(w);
      end
      m_vv  = g;
      nl    = nl | (irq_req & ~m_prev);
      m_prev = irq_req;
      m_lat = nl;
      m_isr = ni;
      if (mask_we) m_en = mask_wdata;
      if (base_we) m_base = base_wdata;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cpu_int == model_int(), "R3 cpu_int", cpu_int, model_int());
      chk(vec_valid == m_vv, "R4 vec_valid", vec_valid, m_vv);
      if (m_vv) begin
        chk(vec_out == m_vec, "R4 vec_out", vec_out, m_vec);
        chk(svc_addr == {m_vec, 2'b00}, "R9 svc_addr", svc_addr, {m_vec, 2'b00});
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    inta = 1; step(1); inta = 0;
  endtask

  task automatic end_svc();
    eoi = 1; step(1); eoi = 0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 0; irq_req = 0; mask_we = 0; mask_wdata = 0;
    base_we = 0; base_wdata = 0; inta = 0; eoi = 0;
    step(3);
    // R10: outputs after reset
    chk(cpu_int == 0, "R10 cpu_int", cpu_int, 0);
    chk(vec_valid == 0, "R10 vec_valid", vec_valid, 0);
    rst_n = 1;
    step(1);

    // R1: disabled line raises nothing
    irq_req[2] = 1; step(2);
    chk(cpu_int == 0, "R1 masked", cpu_int, 0);
    mask_wdata = 8'hFF; mask_we = 1; step(1); mask_we = 0;
    chk(cpu_int == 1, "R1 released", cpu_int, 1);
    // R11: new base
    base_wdata = 8'h20; base_we = 1; step(1); base_we = 0;
    ack();
    chk(vec_valid == 1 && vec_out == 8'h22, "R11 vector", vec_out, 8'h22);
    chk(svc_addr == 10'h088, "R9 address", svc_addr, 10'h088);
    step(1);
    // R2: held line is not relatched
    chk(vec_valid == 0 && cpu_int == 0, "R2 held line", cpu_int, 0);
    end_svc(); irq_req[2] = 0; step(1);

    // nesting: 6 served, repeat of 6 waits, 1 preempts, 3 waits
    irq_req[6] = 1; step(1);
    chk(cpu_int == 1, "R3 single", cpu_int, 1);
    ack();
    chk(vec_out == 8'h26, "R4 line6", vec_out, 8'h26);
    irq_req[6] = 0; step(1); irq_req[6] = 1; step(2);
    chk(cpu_int == 0, "R6 equal level", cpu_int, 0);
    irq_req[1] = 1; step(1);
    chk(cpu_int == 1, "R5 preempt", cpu_int, 1);
    ack();
    chk(vec_out == 8'h21, "R5 vector", vec_out, 8'h21);
    irq_req[3] = 1; step(2);
    chk(cpu_int == 0, "R6 lower waits", cpu_int, 0);
    end_svc();
    chk(cpu_int == 1, "R7 pending outranks", cpu_int, 1);
    ack();
    chk(vec_out == 8'h23, "R7 vector", vec_out, 8'h23);
    end_svc();
    chk(cpu_int == 0, "R7 back to preempted", cpu_int, 0);
    end_svc();
    chk(cpu_int == 1, "R7 stack empty", cpu_int, 1);
    ack(); end_svc();
    irq_req = 0; step(2);

    // R8: spurious acknowledge
    ack();
    chk(vec_valid == 0, "R8 spurious", vec_valid, 0);

    // R3: simultaneous lines, lower index wins
    irq_req[4] = 1; irq_req[7] = 1; step(1);
    ack();
    chk(vec_out == 8'h24, "R3 tie", vec_out, 8'h24);
    end_svc();
    // R1: disable line 7 while it waits
    mask_wdata = 8'h7F; mask_we = 1; step(1); mask_we = 0; step(1);
    chk(cpu_int == 0, "R1 late mask", cpu_int, 0);
    // R11: base wrap
    base_wdata = 8'hFE; base_we = 1; mask_wdata = 8'hFF; mask_we = 1;
    step(1); base_we = 0; mask_we = 0;
    ack();
    chk(vec_out == 8'h05, "R11 wrap", vec_out, 8'h05);
    end_svc(); irq_req = 0; step(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule